// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the host-facing side of a PC-style keyboard and mouse controller. The host sees two byte ports. The data port sits at I/O offset 0x60, and the command/status port sits at offset 0x64. Each port has a single-cycle write strobe. A read of the command/status port returns the status byte, which the block drives continuously on `status_byte`. Reads of the data port belong to the output-buffer logic, which is outside this block.

A byte written to the command port is decoded as a controller command. Some commands act at once: they answer with a byte, or they set or clear a mode bit. Others are two-phase: they latch a pending target, and the next data-port write is steered there. The possible targets are the mode register, the output port, the output buffer (marked as keyboard or as auxiliary data), and the mouse. When no target is pending, a data-port write goes to the keyboard.

Response bytes leave on a valid/ready channel toward the output buffer. Bytes bound for the keyboard and for the mouse leave on their own valid/ready channels. Each of these channels has a small queue, so a stalled sink does not lose data.

Top module: `kbc_host_port`

## Requirements
- R1: After reset the status byte is 0x18, the output port byte is 0xCF, `xlat_en` is 0, and all three output channels are idle. A read-mode command (0x20) issued straight after reset answers 0x03.
- R2: Command 0x20 queues the current mode byte as a response with `rsp_aux` = 0.
- R3: Command 0xAA sets status bit 2 and queues 0x55. Commands 0xA9 and 0xAB each queue 0x00. Command 0xC0 queues 0x80. Status bit 2 stays set once set.
- R4: Command 0xAD sets mode bit 4 and 0xAE clears it. Command 0xA7 sets mode bit 5 and 0xA8 clears it. No other mode bit changes.
- R5: After command 0x60, the next data-port byte is written into the mode register. `xlat_en` always equals mode bit 6.
- R6: After 0xD1, the next data byte is written to the output port. After 0xD2, it is queued as a response with `rsp_aux` = 0. After 0xD3, it is queued as a response with `rsp_aux` = 1. After 0xD4, it is sent on the mouse channel.
- R7: A data-port write with no target pending is sent on the keyboard channel. Any data-port write clears the pending target, so the following data byte goes to the keyboard.
- R8: Status bit 3 is set by every command-port write and cleared by every data-port write. Status bit 4 always reads 1. Bits 0, 1, 5, 6 and 7 always read 0. If both strobes are asserted in one cycle, the command is taken and the data byte is dropped.
- R9: An unrecognised command byte changes nothing except status bit 3. The mode register, the output port and the pending target are left as they were, and no byte is queued.
- R10: While an output channel is valid and not ready, its byte stays stable. Up to the queue depth (default 2) of bytes pushed during a stall are all delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe, command port (offset 0x64) |
| data_wr | input | 1 | Write strobe, data port (offset 0x60) |
| host_wdata | input | 8 | Byte written by the host |
| status_byte | output | 8 | Status register, read at offset 0x64 |
| outport_byte | output | 8 | Controller output port value |
| xlat_en | output | 1 | Scan-code translation enable (mode bit 6) |
| rsp_valid | output | 1 | Response byte available for the output buffer |
| rsp_ready | input | 1 | Output buffer accepts the response |
| rsp_data | output | 8 | Response byte |
| rsp_aux | output | 1 | Response is marked as auxiliary-device data |
| kbd_valid | output | 1 | Byte available for the keyboard |
| kbd_ready | input | 1 | Keyboard side accepts the byte |
| kbd_data | output | 8 | Byte for the keyboard |
| mouse_valid | output | 1 | Byte available for the mouse |
| mouse_ready | input | 1 | Mouse side accepts the byte |
| mouse_data | output | 8 | Byte for the mouse |

## Verification
Random sequences mix known command codes, arbitrary command bytes and data writes. Because of this, a data byte arrives under every pending target, and under none. This shows whether the steering follows the last two-phase command, and whether that target is released after exactly one byte.

Directed cases cover three things. One is the reset values. Another is an unrecognised command placed between a two-phase command and its data byte, which shows that the pending target survives it. The last is a stalled response queue holding two answers, which shows that the bytes are held and keep their order.

// File: rtl/kbc_pkg.sv
// Package: shared command codes, reset values, bit positions and the
// decoded-action record used between the decoder and the register block.
package kbc_pkg;

    localparam logic [7:0] OP_READ_MODE    = 8'h20;
    localparam logic [7:0] OP_WRITE_MODE   = 8'h60;
    localparam logic [7:0] OP_AUX_OFF      = 8'hA7;
    localparam logic [7:0] OP_AUX_ON       = 8'hA8;
    localparam logic [7:0] OP_AUX_TEST     = 8'hA9;
    localparam logic [7:0] OP_SELF_TEST    = 8'hAA;
    localparam logic [7:0] OP_KBD_TEST     = 8'hAB;
    localparam logic [7:0] OP_KBD_OFF      = 8'hAD;
    localparam logic [7:0] OP_KBD_ON       = 8'hAE;
    localparam logic [7:0] OP_READ_INPUT   = 8'hC0;
    localparam logic [7:0] OP_WRITE_OUTP   = 8'hD1;
    localparam logic [7:0] OP_WRITE_OBUF   = 8'hD2;
    localparam logic [7:0] OP_WRITE_AUXBUF = 8'hD3;
    localparam logic [7:0] OP_WRITE_AUXDEV = 8'hD4;

    localparam logic [7:0] MODE_RESET   = 8'h03;
    localparam logic [7:0] STATUS_RESET = 8'h18;
    localparam logic [7:0] OUTP_RESET   = 8'hCF;

    localparam logic [7:0] SELFTEST_PASS = 8'h55;
    localparam logic [7:0] IFACE_OK      = 8'h00;
    localparam logic [7:0] INPUT_PORT    = 8'h80;

    localparam int ST_SELFTEST = 2;
    localparam int ST_CMD      = 3;
    localparam int ST_UNLOCK   = 4;
    localparam int MD_KBD_OFF  = 4;
    localparam int MD_AUX_OFF  = 5;
    localparam int MD_XLAT     = 6;

    // Where the next data-port byte goes; TGT_KBD means nothing pending.
    typedef enum logic [2:0] {
        TGT_KBD,
        TGT_MODE,
        TGT_OUTP,
        TGT_OBUF,
        TGT_AUXBUF,
        TGT_AUXDEV
    } tgt_e;

    typedef struct packed {
        logic       push_rsp;
        logic       rsp_is_mode;
        logic [7:0] rsp_const;
        logic       set_selftest;
        logic [7:0] mode_set;
        logic [7:0] mode_clr;
        logic       load_tgt;
        tgt_e       tgt;
    } cmd_act_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
// Module: kbc_cmd_decode
// Turns one command byte into an action record. Purely combinational.
// Assumes the caller applies the record only in a cycle with a command
// write. Unknown codes yield an all-idle record.
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_act_t   act
);

    // Decode table: one branch per recognised command.
    always_comb begin
        act = '0;
        act.tgt = TGT_KBD;
        case (cmd_byte)
            OP_READ_MODE: begin
                act.push_rsp    = 1'b1;
                act.rsp_is_mode = 1'b1;
            end
            OP_SELF_TEST: begin
                act.push_rsp     = 1'b1;
                act.rsp_const    = SELFTEST_PASS;
                act.set_selftest = 1'b1;
            end
            OP_AUX_TEST, OP_KBD_TEST: begin
                act.push_rsp  = 1'b1;
                act.rsp_const = IFACE_OK;
            end
            OP_READ_INPUT: begin
                act.push_rsp  = 1'b1;
                act.rsp_const = INPUT_PORT;
            end
            OP_AUX_OFF: act.mode_set[MD_AUX_OFF] = 1'b1;
            OP_AUX_ON:  act.mode_clr[MD_AUX_OFF] = 1'b1;
            OP_KBD_OFF: act.mode_set[MD_KBD_OFF] = 1'b1;
            OP_KBD_ON:  act.mode_clr[MD_KBD_OFF] = 1'b1;
            OP_WRITE_MODE: begin
                act.load_tgt = 1'b1;
                act.tgt      = TGT_MODE;
            end
            OP_WRITE_OUTP: begin
                act.load_tgt = 1'b1;
                act.tgt      = TGT_OUTP;
            end
            OP_WRITE_OBUF: begin
                act.load_tgt = 1'b1;
                act.tgt      = TGT_OBUF;
            end
            OP_WRITE_AUXBUF: begin
                act.load_tgt = 1'b1;
                act.tgt      = TGT_AUXBUF;
            end
            OP_WRITE_AUXDEV: begin
                act.load_tgt = 1'b1;
                act.tgt      = TGT_AUXDEV;
            end
            default: ;
        endcase
    end

    // R9: a code never both answers and arms a target, nor sets and clears one bit.
    always_comb begin
        a_r9_exclusive_action: assert (!(act.push_rsp && act.load_tgt));
        a_r4_set_clr_disjoint: assert ((act.mode_set & act.mode_clr) == 8'h00);
    end

endmodule

// File: rtl/kbc_byte_fifo.sv
// Module: kbc_byte_fifo
// Small synchronous queue with a valid/ready output side. Assumes the
// producer respects the depth. A push into a full queue is dropped.
// Simultaneous push and pop are allowed.
module kbc_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign out_valid = (cnt != '0);
    assign out_data  = mem[rd_ptr];
    assign do_push   = push && (cnt != FULL);
    assign do_pop    = out_valid && pop_ready;

    // Storage write, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R10: a stalled head byte stays offered and unchanged.
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !pop_ready |=> out_valid && $stable(out_data));

    // R10: occupancy never exceeds the depth.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

endmodule

// File: rtl/kbc_host_port.sv
// Module: kbc_host_port
// Host side of the keyboard controller. It holds the mode, status, output
// port and pending-target registers, and queues bytes for the output buffer,
// the keyboard and the mouse. Assumes at most one strobe per cycle is
// meaningful: a command write wins over a simultaneous data write.
module kbc_host_port
    import kbc_pkg::*;
#(
    parameter int RSP_DEPTH = 2,
    parameter int TX_DEPTH  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       data_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] status_byte,
    output logic [7:0] outport_byte,
    output logic       xlat_en,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic [7:0] rsp_data,
    output logic       rsp_aux,
    output logic       kbd_valid,
    input  logic       kbd_ready,
    output logic [7:0] kbd_data,
    output logic       mouse_valid,
    input  logic       mouse_ready,
    output logic [7:0] mouse_data
);

    localparam int RSP_W = 9;

    cmd_act_t   act;
    logic [7:0] mode_q;
    logic [7:0] outp_q;
    logic       selftest_q;
    logic       cmd_flag_q;
    tgt_e       tgt_q;
    logic       data_take;

    logic             rsp_push;
    logic [RSP_W-1:0] rsp_word;
    logic             kbd_push;
    logic             mouse_push;

    kbc_cmd_decode u_decode (
        .cmd_byte (host_wdata),
        .act      (act)
    );

    assign data_take = data_wr && !cmd_wr;

    // Mode register: bit set/clear from commands, full load from the data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (cmd_wr) begin
            mode_q <= (mode_q | act.mode_set) & ~act.mode_clr;
        end else if (data_take && tgt_q == TGT_MODE) begin
            mode_q <= host_wdata;
        end
    end

    // Output port register: loaded only by a data byte aimed at it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outp_q <= OUTP_RESET;
        end else if (data_take && tgt_q == TGT_OUTP) begin
            outp_q <= host_wdata;
        end
    end

    // Pending target: armed by two-phase commands, released by any data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= TGT_KBD;
        end else if (cmd_wr) begin
            if (act.load_tgt) tgt_q <= act.tgt;
        end else if (data_wr) begin
            tgt_q <= TGT_KBD;
        end
    end

    // Status flags: self-test is sticky, the command flag tracks the last port written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selftest_q <= STATUS_RESET[ST_SELFTEST];
            cmd_flag_q <= STATUS_RESET[ST_CMD];
        end else begin
            if (cmd_wr && act.set_selftest) selftest_q <= 1'b1;
            if (cmd_wr)       cmd_flag_q <= 1'b1;
            else if (data_wr) cmd_flag_q <= 1'b0;
        end
    end

    // Status byte assembly: only the flags this block owns are nonzero.
    always_comb begin
        status_byte = 8'h00;
        status_byte[ST_SELFTEST] = selftest_q;
        status_byte[ST_CMD]      = cmd_flag_q;
        status_byte[ST_UNLOCK]   = 1'b1;
    end

    // Response source selection: a command answer or a data byte put into the buffer.
    always_comb begin
        rsp_push = 1'b0;
        rsp_word = '0;
        if (cmd_wr) begin
            rsp_push = act.push_rsp;
            rsp_word = {1'b0, act.rsp_is_mode ? mode_q : act.rsp_const};
        end else if (data_take && (tgt_q == TGT_OBUF || tgt_q == TGT_AUXBUF)) begin
            rsp_push = 1'b1;
            rsp_word = {(tgt_q == TGT_AUXBUF), host_wdata};
        end
    end

    assign kbd_push   = data_take && (tgt_q == TGT_KBD);
    assign mouse_push = data_take && (tgt_q == TGT_AUXDEV);
    assign outport_byte = outp_q;
    assign xlat_en      = mode_q[MD_XLAT];

    kbc_byte_fifo #(.W(RSP_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_push),
        .push_data (rsp_word),
        .pop_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_data  ({rsp_aux, rsp_data})
    );

    kbc_byte_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_kbd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (kbd_push),
        .push_data (host_wdata),
        .pop_ready (kbd_ready),
        .out_valid (kbd_valid),
        .out_data  (kbd_data)
    );

    kbc_byte_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_mouse_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mouse_push),
        .push_data (host_wdata),
        .pop_ready (mouse_ready),
        .out_valid (mouse_valid),
        .out_data  (mouse_data)
    );

    // R8: a command write leaves the command flag set.
    a_r8_cmd_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> status_byte[ST_CMD]);

    // R8: a lone data write leaves the command flag clear.
    a_r8_data_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !cmd_wr |=> !status_byte[ST_CMD]);

    // R3: self-test flag is sticky once set.
    a_r3_selftest_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[ST_SELFTEST] |=> status_byte[ST_SELFTEST]);

    // R6: the output port only moves on a data write.
    a_r6_outport_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(outport_byte));

    // R5: translation enable only moves on a data write.
    a_r5_xlat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(xlat_en));

    // R7: keyboard and mouse channels never receive the same data byte.
    a_r7_single_sink: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_push && mouse_push));

endmodule

// File: tb/test_kbc_host_port.sv
module test_kbc_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] status_byte, outport_byte, rsp_data, kbd_data, mouse_data;
    logic       xlat_en, rsp_valid, rsp_aux, kbd_valid, mouse_valid;
    logic       rsp_ready = 1'b0, kbd_ready = 1'b0, mouse_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // expected model state (from the requirements)
    logic [7:0] e_mode, e_outp;
    bit         e_self, e_cmdf;
    int         e_tgt;          // 0 none,1 mode,2 outp,3 obuf,4 auxbuf,5 mouse
    bit         e_rv, e_ra, e_kv, e_mv;
    logic [7:0] e_rd, e_kd, e_md;

    always #10 clk = ~clk;

    kbc_host_port i_kbc_host_port (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .host_wdata(host_wdata), .status_byte(status_byte),
        .outport_byte(outport_byte), .xlat_en(xlat_en),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_aux(rsp_aux), .kbd_valid(kbd_valid), .kbd_ready(kbd_ready),
        .kbd_data(kbd_data), .mouse_valid(mouse_valid),
        .mouse_ready(mouse_ready), .mouse_data(mouse_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {3'b000, 1'b1, e_cmdf, e_self, 2'b00};
    endfunction

    function automatic logic [7:0] known_code(input int i);
        case (i)
            0: return 8'h20;  1: return 8'h60;  2: return 8'hA7;  3: return 8'hA8;
            4: return 8'hA9;  5: return 8'hAA;  6: return 8'hAB;  7: return 8'hAD;
            8: return 8'hAE;  9: return 8'hC0;  10: return 8'hD1; 11: return 8'hD2;
            12: return 8'hD3; default: return 8'hD4;
        endcase
    endfunction

    // expected effect of a command byte
    task automatic model_cmd(input logic [7:0] b);
        e_cmdf = 1'b1;
        case (b)
            8'h20: begin e_rv = 1; e_ra = 0; e_rd = e_mode; end
            8'hAA: begin e_rv = 1; e_ra = 0; e_rd = 8'h55; e_self = 1; end
            8'hA9, 8'hAB: begin e_rv = 1; e_ra = 0; e_rd = 8'h00; end
            8'hC0: begin e_rv = 1; e_ra = 0; e_rd = 8'h80; end
            8'hA7: e_mode[5] = 1'b1;
            8'hA8: e_mode[5] = 1'b0;
            8'hAD: e_mode[4] = 1'b1;
            8'hAE: e_mode[4] = 1'b0;
            8'h60: e_tgt = 1;
            8'hD1: e_tgt = 2;
            8'hD2: e_tgt = 3;
            8'hD3: e_tgt = 4;
            8'hD4: e_tgt = 5;
            default: ;
        endcase
    endtask

    task automatic model_data(input logic [7:0] b);
        e_cmdf = 1'b0;
        case (e_tgt)
            1: e_mode = b;
            2: e_outp = b;
            3: begin e_rv = 1; e_ra = 0; e_rd = b; end
            4: begin e_rv = 1; e_ra = 1; e_rd = b; end
            5: begin e_mv = 1; e_md = b; end
            default: begin e_kv = 1; e_kd = b; end
        endcase
        e_tgt = 0;
    endtask

    task automatic do_cmd(input logic [7:0] b);
        @(negedge clk); cmd_wr = 1'b1; host_wdata = b;
        @(negedge clk); cmd_wr = 1'b0;
        model_cmd(b);
    endtask

    task automatic do_data(input logic [7:0] b);
        @(negedge clk); data_wr = 1'b1; host_wdata = b;
        @(negedge clk); data_wr = 1'b0;
        model_data(b);
    endtask

    // compare registers and channels with the model, then drain the channels
    task automatic check_drain(input string tag);
        chk(status_byte == exp_status(), {tag, " R8 status"}, status_byte, exp_status());
        chk(outport_byte == e_outp, {tag, " R6 outport"}, outport_byte, e_outp);
        chk(xlat_en == e_mode[6], {tag, " R5 xlat"}, xlat_en, e_mode[6]);
        chk(rsp_valid == e_rv, {tag, " R2 rsp_valid"}, rsp_valid, e_rv);
        if (e_rv && rsp_valid)
            chk({rsp_aux, rsp_data} == {e_ra, e_rd}, {tag, " R6 rsp"}, {rsp_aux, rsp_data}, {e_ra, e_rd});
        chk(kbd_valid == e_kv, {tag, " R7 kbd_valid"}, kbd_valid, e_kv);
        if (e_kv && kbd_valid) chk(kbd_data == e_kd, {tag, " R7 kbd"}, kbd_data, e_kd);
        chk(mouse_valid == e_mv, {tag, " R6 mouse_valid"}, mouse_valid, e_mv);
        if (e_mv && mouse_valid) chk(mouse_data == e_md, {tag, " R6 mouse"}, mouse_data, e_md);
        if (rsp_valid || kbd_valid || mouse_valid) begin
            rsp_ready = 1'b1; kbd_ready = 1'b1; mouse_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0; kbd_ready = 1'b0; mouse_ready = 1'b0;
        end
        e_rv = 0; e_kv = 0; e_mv = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        e_mode = 8'h03; e_outp = 8'hCF; e_self = 0; e_cmdf = 1; e_tgt = 0;
        e_rv = 0; e_ra = 0; e_kv = 0; e_mv = 0; e_rd = 0; e_kd = 0; e_md = 0;
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(status_byte == 8'h18, "R1 status reset", status_byte, 8'h18);
        chk(outport_byte == 8'hCF, "R1 outport reset", outport_byte, 8'hCF);
        chk(xlat_en == 1'b0, "R1 xlat reset", xlat_en, 0);
        chk(!rsp_valid && !kbd_valid && !mouse_valid, "R1 idle", {rsp_valid, kbd_valid, mouse_valid}, 0);
        do_cmd(8'h20);
        chk(rsp_data == 8'h03 && rsp_valid, "R1 mode reset via 0x20", rsp_data, 8'h03);
        check_drain("R1");

        // R3 directed answers
        do_cmd(8'hAA); check_drain("R3 AA");
        chk(status_byte[2], "R3 selftest bit", status_byte, 8'h1C);
        do_cmd(8'hC0); check_drain("R3 C0");

        // R4 mode bits, read back through 0x20
        do_cmd(8'hAD); do_cmd(8'hA7); do_cmd(8'h20);
        chk(rsp_data == 8'h33, "R4 both disabled", rsp_data, 8'h33);
        check_drain("R4a");
        do_cmd(8'hAE); do_cmd(8'h20); check_drain("R4b");

        // R5 mode load and translation bit
        do_cmd(8'h60); do_data(8'h47); check_drain("R5 load");
        chk(xlat_en == 1'b1, "R5 xlat set", xlat_en, 1);

        // R9 unknown command between a two-phase command and its data byte
        do_cmd(8'hD3); do_cmd(8'hF7); check_drain("R9 unknown");
        do_data(8'h5A); check_drain("R9 target kept");
        do_cmd(8'h20); check_drain("R9 mode unchanged");

        // R7 pending cleared after one byte
        do_cmd(8'hD4); do_data(8'h11); check_drain("R6 mouse");
        do_data(8'h22); check_drain("R7 back to keyboard");

        // R10 stalled responses held and ordered
        do_cmd(8'hAA); do_cmd(8'hA9);
        repeat (3) begin
            @(negedge clk);
            chk(rsp_valid && rsp_data == 8'h55, "R10 held first", rsp_data, 8'h55);
        end
        rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
        chk(rsp_valid && rsp_data == 8'h00, "R10 second kept", rsp_data, 8'h00);
        rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
        chk(!rsp_valid, "R10 drained", rsp_valid, 0);
        e_rv = 0;

        // R8 simultaneous strobes: command taken, data dropped
        @(negedge clk); cmd_wr = 1'b1; data_wr = 1'b1; host_wdata = 8'hAB;
        @(negedge clk); cmd_wr = 1'b0; data_wr = 1'b0;
        model_cmd(8'hAB);
        check_drain("R8 both strobes");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            if (r % 4 == 0) do_data(8'($urandom));
            else if (r % 8 < 6) do_cmd(known_code(int'($urandom % 14)));
            else do_cmd(8'($urandom));
            check_drain("random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule